// File: doc/BRIEF.md
# Passive Host Byte Port

This block is a slave-only byte-wide port. An external microprocessor uses it to read a word that the core side has posted and to write a word that the core side then collects. The host always drives the strobes. The block never starts a cycle on its own. A configuration input selects the host bus style, either separate read and write strobes or a read/write level with a single data strobe. A second configuration input selects whole-word transfers, done in two byte accesses, or single-byte transfers.

All host pins are brought into the internal clock domain through a synchroniser chain of configurable depth. An access takes effect when its strobe is released. The pad data is split into an input, an output and an output enable, so the pad ring builds the three-state driver. The output enable follows the raw pins, so read data reaches the bus without waiting for the synchroniser.

On the core side there is a posted outbound word with an `out_full` flag, which a host read clears. There is also a received inbound word with an `in_full` flag, which the core clears with a one-cycle acknowledge.

Top module: `hp_port`

## Requirements
- R1: After reset, `in_full` and `out_full` are 0, `in_word` is 0 and `hp_doe` is 0.
- R2: With `cfg_proto`=0 (split strobes), `hp_ctl_a` low is a read strobe and `hp_ctl_b` low is a write strobe, each qualified by `hp_cs_n` low.
- R3: With `cfg_proto`=1, `hp_ctl_b` low is the data strobe and `hp_ctl_a` gives the direction (1 = read, 0 = write), qualified by `hp_cs_n` low.
- R4: With `cfg_wide`=0, a completed host write loads `in_word` with the byte in bits 7:0 and zero in bits 15:8, and sets `in_full`.
- R5: With `cfg_wide`=1, a write with `hp_byte_hi`=0 only stages the low byte. A following write with `hp_byte_hi`=1 loads `in_word` as {high, staged low} and sets `in_full`.
- R6: With `cfg_wide`=0, a host read presents bits 7:0 of the posted word on `hp_dout` and clears `out_full` when it completes.
- R7: With `cfg_wide`=1, `hp_byte_hi` selects bits 15:8 (1) or 7:0 (0) on `hp_dout`. A completed low-byte read leaves `out_full` set, and a completed high-byte read clears it.
- R8: `hp_doe` is 1 exactly while `hp_cs_n` is low and the pins encode an active read for the selected style. Otherwise it is 0.
- R9: `core_out_we` loads `out_word` and sets `out_full` on the next clock. `core_in_ack` clears `in_full` on the next clock.
- R10: While a host strobe is held asserted, neither flag nor `in_word` changes. The access acts only after the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_proto | input | 1 | Bus style: 0 split strobes, 1 direction level plus data strobe |
| cfg_wide | input | 1 | 1 word transfers over two bytes, 0 single byte |
| hp_cs_n | input | 1 | Host select, active low |
| hp_ctl_a | input | 1 | Read strobe (style 0) or direction level (style 1) |
| hp_ctl_b | input | 1 | Write strobe (style 0) or data strobe (style 1) |
| hp_byte_hi | input | 1 | Byte lane select in word mode |
| hp_din | input | 8 | Byte from the host bus |
| hp_dout | output | 8 | Byte toward the host bus |
| hp_doe | output | 1 | Pad driver enable for hp_dout |
| core_out_we | input | 1 | Core posts `core_out_wdata` |
| core_out_wdata | input | 16 | Word to post for the host |
| out_full | output | 1 | Posted word not yet fully read by the host |
| core_in_ack | input | 1 | Core has taken `in_word` |
| in_word | output | 16 | Last word written by the host |
| in_full | output | 1 | Host word waiting for the core |

## Verification
The bench builds the block with its default 8-bit lanes and two synchroniser stages. It compares the enable and byte on the host bus against a behavioural model on every clock. At those values, both bus styles and both transfer widths can be reached with short, exactly timed accesses. Each access has a known release-to-effect latency. A held strobe lets the bench confirm that nothing acts before the strobe is released, and the two-access word sequences expose staging and lane-order faults.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef enum logic {
        PROTO_SPLIT = 1'b0,
        PROTO_RWDS  = 1'b1
    } hp_proto_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];
    logic [W-1:0] pipe_d [STAGES];

    always_comb begin
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_V;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/hp_decode.sv
module hp_decode #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hp_pkg::hp_proto_e proto,
    input  logic              cs_n,
    input  logic              ctl_a,
    input  logic              ctl_b,
    input  logic              byte_hi,
    input  logic [BYTE_W-1:0] din,
    output logic              xfer_end,
    output logic              xfer_rd,
    output logic              xfer_hi,
    output logic [BYTE_W-1:0] xfer_data
);
    typedef struct packed {
        logic              active;
        logic              rd;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } dec_t;

    dec_t st_d, st_q;
    logic act_now, rd_now;

    always_comb begin
        if (proto == hp_pkg::PROTO_SPLIT) begin
            act_now = !cs_n && (!ctl_a || !ctl_b);
            rd_now  = !ctl_a;
        end else begin
            act_now = !cs_n && !ctl_b;
            rd_now  = ctl_a;
        end
        st_d        = st_q;
        st_d.active = act_now;
        if (act_now) begin
            st_d.rd   = rd_now;
            st_d.hi   = byte_hi;
            st_d.data = din;
        end
        xfer_end  = st_q.active && !act_now;
        xfer_rd   = st_q.rd;
        xfer_hi   = st_q.hi;
        xfer_data = st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hp_regs.sv
module hp_regs #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              xfer_end,
    input  logic              xfer_rd,
    input  logic              xfer_hi,
    input  logic [BYTE_W-1:0] xfer_data,
    input  logic              core_out_we,
    input  logic [WORD_W-1:0] core_out_wdata,
    input  logic              core_in_ack,
    output logic [WORD_W-1:0] out_word,
    output logic              out_full,
    output logic [WORD_W-1:0] in_word,
    output logic              in_full
);
    typedef struct packed {
        logic [WORD_W-1:0] out_word;
        logic              out_full;
        logic [WORD_W-1:0] in_word;
        logic              in_full;
        logic [BYTE_W-1:0] stage;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_done, rd_done;

    always_comb begin
        st_d    = st_q;
        wr_done = 1'b0;
        rd_done = 1'b0;
        if (xfer_end && !xfer_rd) begin
            if (!wide) begin
                st_d.in_word = {{BYTE_W{1'b0}}, xfer_data};
                wr_done      = 1'b1;
            end else if (!xfer_hi) begin
                st_d.stage = xfer_data;
            end else begin
                st_d.in_word = {xfer_data, st_q.stage};
                wr_done      = 1'b1;
            end
        end
        if (xfer_end && xfer_rd && (!wide || xfer_hi)) begin
            rd_done = 1'b1;
        end
        if (wr_done)          st_d.in_full = 1'b1;
        else if (core_in_ack) st_d.in_full = 1'b0;
        if (core_out_we) begin
            st_d.out_word = core_out_wdata;
            st_d.out_full = 1'b1;
        end else if (rd_done) begin
            st_d.out_full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_word = st_q.out_word;
    assign out_full = st_q.out_full;
    assign in_word  = st_q.in_word;
    assign in_full  = st_q.in_full;
endmodule

// File: rtl/hp_port.sv
module hp_port #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = 2 * BYTE_W,
    localparam int SYNC_W     = BYTE_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_proto,
    input  logic              cfg_wide,
    input  logic              hp_cs_n,
    input  logic              hp_ctl_a,
    input  logic              hp_ctl_b,
    input  logic              hp_byte_hi,
    input  logic [BYTE_W-1:0] hp_din,
    output logic [BYTE_W-1:0] hp_dout,
    output logic              hp_doe,
    input  logic              core_out_we,
    input  logic [WORD_W-1:0] core_out_wdata,
    output logic              out_full,
    input  logic              core_in_ack,
    output logic [WORD_W-1:0] in_word,
    output logic              in_full
);
    localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, 1'b0, {BYTE_W{1'b0}}};

    logic [SYNC_W-1:0] pins_raw, pins_s;
    logic              cs_n_s, ctl_a_s, ctl_b_s, hi_s;
    logic [BYTE_W-1:0] din_s;
    logic              xfer_end, xfer_rd, xfer_hi;
    logic [BYTE_W-1:0] xfer_data;
    logic [WORD_W-1:0] out_word;
    hp_pkg::hp_proto_e proto;

    assign proto    = hp_pkg::hp_proto_e'(cfg_proto);
    assign pins_raw = {hp_cs_n, hp_ctl_a, hp_ctl_b, hp_byte_hi, hp_din};
    assign {cs_n_s, ctl_a_s, ctl_b_s, hi_s, din_s} = pins_s;

    hp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_V(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    hp_decode #(.BYTE_W(BYTE_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .proto(proto),
        .cs_n(cs_n_s), .ctl_a(ctl_a_s), .ctl_b(ctl_b_s),
        .byte_hi(hi_s), .din(din_s),
        .xfer_end(xfer_end), .xfer_rd(xfer_rd), .xfer_hi(xfer_hi),
        .xfer_data(xfer_data)
    );

    hp_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wide(cfg_wide),
        .xfer_end(xfer_end), .xfer_rd(xfer_rd), .xfer_hi(xfer_hi),
        .xfer_data(xfer_data),
        .core_out_we(core_out_we), .core_out_wdata(core_out_wdata),
        .core_in_ack(core_in_ack),
        .out_word(out_word), .out_full(out_full),
        .in_word(in_word), .in_full(in_full)
    );

    // Bus drive follows the raw pins so read data needs no sync latency.
    always_comb begin
        if (proto == hp_pkg::PROTO_SPLIT) hp_doe = !hp_cs_n && !hp_ctl_a;
        else                              hp_doe = !hp_cs_n && !hp_ctl_b && hp_ctl_a;
        hp_dout = (cfg_wide && hp_byte_hi) ? out_word[WORD_W-1:BYTE_W]
                                           : out_word[BYTE_W-1:0];
    end
endmodule

// File: rtl/hp_port_chk.sv
module hp_port_chk #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wide,
    input logic              hp_cs_n,
    input logic              hp_doe,
    input logic              core_out_we,
    input logic              core_in_ack,
    input logic              in_full,
    input logic              out_full,
    input logic [WORD_W-1:0] in_word,
    input logic              xfer_end,
    input logic              xfer_rd,
    input logic              xfer_hi
);
    AST_DOE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        hp_doe |-> !hp_cs_n);  // R8
    AST_LOAD_SETS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        core_out_we |=> out_full);  // R9
    AST_IN_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_full) |-> $past(core_in_ack));  // R9
    AST_IN_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> $past(xfer_end && !xfer_rd && (!cfg_wide || xfer_hi)));  // R5
    AST_OUT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_full) |-> $past(xfer_end && xfer_rd && (!cfg_wide || xfer_hi)));  // R7
    AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_full) && !cfg_wide) |-> (in_word[WORD_W-1:BYTE_W] == '0));  // R4
endmodule

bind hp_port hp_port_chk #(.BYTE_W(BYTE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .hp_cs_n(hp_cs_n),
    .hp_doe(hp_doe), .core_out_we(core_out_we), .core_in_ack(core_in_ack),
    .in_full(in_full), .out_full(out_full), .in_word(in_word),
    .xfer_end(xfer_end), .xfer_rd(xfer_rd), .xfer_hi(xfer_hi)
);

// File: tb/test_hp_port.sv
module test_hp_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_proto = 1'b0, cfg_wide = 1'b0;
    logic        hp_cs_n = 1'b1, hp_ctl_a = 1'b1, hp_ctl_b = 1'b1, hp_byte_hi = 1'b0;
    logic [7:0]  hp_din = '0;
    logic [7:0]  hp_dout;
    logic        hp_doe;
    logic        core_out_we = 1'b0;
    logic [15:0] core_out_wdata = '0;
    logic        out_full;
    logic        core_in_ack = 1'b0;
    logic [15:0] in_word;
    logic        in_full;

    int checks = 0, errors = 0;
    logic [15:0] m_in = '0, m_out = '0;
    logic [7:0]  m_stage = '0;
    logic        m_in_full = 1'b0, m_out_full = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_port i_hp_port (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the posted word: a core load takes effect at the clock edge.
    always @(posedge clk) if (rst_n && core_out_we) m_out <= core_out_wdata;

    // Every-clock comparison of the host bus side.
    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_oe;
            exp_oe = !hp_cs_n && (cfg_proto ? (!hp_ctl_b && hp_ctl_a) : !hp_ctl_a);
            check("R8 doe", {31'b0, hp_doe}, {31'b0, exp_oe});
            if (exp_oe)
                check("R7 dout", {24'b0, hp_dout},
                      {24'b0, (cfg_wide && hp_byte_hi) ? m_out[15:8] : m_out[7:0]});
        end
    end

    task automatic flags(string req);
        check({req, " in_full"}, {31'b0, in_full}, {31'b0, m_in_full});
        check({req, " out_full"}, {31'b0, out_full}, {31'b0, m_out_full});
        check({req, " in_word"}, {16'b0, in_word}, {16'b0, m_in});
    endtask

    task automatic host(string req, bit rd, bit hi, logic [7:0] d, bit probe = 0);
        @(negedge clk);
        hp_cs_n = 1'b0; hp_byte_hi = hi; hp_din = d;
        if (cfg_proto) hp_ctl_a = rd ? 1'b1 : 1'b0;
        repeat (2) @(negedge clk);
        if (cfg_proto) hp_ctl_b = 1'b0;
        else if (rd)   hp_ctl_a = 1'b0;
        else           hp_ctl_b = 1'b0;
        repeat (5) @(negedge clk);
        if (probe) flags("R10 held");
        if (rd) begin
            check({req, " rd byte"}, {24'b0, hp_dout},
                  {24'b0, (cfg_wide && hi) ? m_out[15:8] : m_out[7:0]});
        end
        if (cfg_proto) hp_ctl_b = 1'b1;
        else begin hp_ctl_a = 1'b1; hp_ctl_b = 1'b1; end
        repeat (3) @(negedge clk);
        hp_cs_n = 1'b1; hp_ctl_a = 1'b1;
        repeat (3) @(negedge clk);
        if (!rd) begin
            if (!cfg_wide) begin m_in = {8'h00, d}; m_in_full = 1'b1; end
            else if (!hi)  m_stage = d;
            else begin m_in = {d, m_stage}; m_in_full = 1'b1; end
        end else if (!cfg_wide || hi) m_out_full = 1'b0;
        flags(req);
    endtask

    task automatic core_load(logic [15:0] w);
        @(negedge clk);
        core_out_we = 1'b1; core_out_wdata = w;
        @(negedge clk);
        core_out_we = 1'b0;
        m_out_full = 1'b1;
        flags("R9 load");
    endtask

    task automatic core_ack();
        @(negedge clk);
        core_in_ack = 1'b1;
        @(negedge clk);
        core_in_ack = 1'b0;
        m_in_full = 1'b0;
        flags("R9 ack");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 doe", {31'b0, hp_doe}, 32'd0);
        flags("R1 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        flags("R1 after");

        // split strobes, byte mode
        cfg_proto = 1'b0; cfg_wide = 1'b0;
        host("R4 R2 write", 1'b0, 1'b0, 8'h5A, 1'b1);
        core_ack();
        core_load(16'hBEEF);
        host("R6 R2 read", 1'b1, 1'b0, 8'h00);

        // split strobes, word mode
        cfg_wide = 1'b1;
        host("R5 low stage", 1'b0, 1'b0, 8'h34);
        host("R5 high", 1'b0, 1'b1, 8'h12, 1'b1);
        core_ack();
        core_load(16'hA1B2);
        host("R7 low read", 1'b1, 1'b0, 8'h00);
        host("R7 high read", 1'b1, 1'b1, 8'h00);

        // direction + data strobe style
        cfg_proto = 1'b1;
        host("R3 low stage", 1'b0, 1'b0, 8'h78);
        host("R3 high", 1'b0, 1'b1, 8'h56);
        core_load(16'hC0DE);
        host("R3 low read", 1'b1, 1'b0, 8'h00);
        host("R3 high read", 1'b1, 1'b1, 8'h00);
        cfg_wide = 1'b0;
        core_ack();
        host("R3 R4 byte write", 1'b0, 1'b1, 8'hC3);
        core_load(16'h9D4E);
        host("R3 R6 byte read", 1'b1, 1'b1, 8'h00);

        // R8: strobe without select drives nothing and acts on nothing
        @(negedge clk);
        hp_ctl_a = 1'b1; hp_ctl_b = 1'b0;
        repeat (8) @(negedge clk);
        check("R8 no sel", {31'b0, hp_doe}, 32'd0);
        hp_ctl_b = 1'b1;
        repeat (6) @(negedge clk);
        flags("R8 no sel");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule